// File: doc/BRIEF.md
# Triggered Command Set Sequencer

This block is a register-mapped engine that holds several command sets. Each set has a small group of control registers and a row of command slots. A slot holds a message word, a target address and a payload. Software fills the slots of an idle set and marks which of them take part. It then fires the set in two steps: it first sets the mode enable and then, in a separate write, the trigger.

Once fired, the set is busy. A shared issue engine sends the set's enabled slots downstream one at a time over a valid/ready request port. It goes through the slots in ascending index order and serves the lowest-numbered busy set first. For each command it records an issued flag. When a response comes back for a command that asked for one, it also records a completed flag. A set goes back to idle after all of its enabled commands have been issued and every command marked in its wait bitmap has completed. It then raises its own bit in a shared interrupt status register. An enable mask gates that register onto a single interrupt line.

The register map is laid out in bytes. The shared registers sit at the bottom of the map. Set s starts at SET_BASE + 672·s. Slot c of a set starts 0x30 + 20·c bytes into the set.

Top module: `tcs_seq`

## Requirements
- R1: After reset every set is idle and its status register (set offset 0x18) reads 1. Interrupt status (0x04) reads 0, irq is low and req_valid is low.
- R2: The shared configuration word at 0x0C reads NUM_CMDS in bits [31:27] and NUM_SETS in bits [5:0]. Each slot has three read/write words at slot offsets 0x00 (message), 0x04 (address) and 0x08 (payload). A word written at set s, slot c reads back at the same address.
- R3: The control register sits at set offset 0x14, with bit 16 as the mode enable and bit 24 as the trigger. A write launches an idle set only if it sets bit 24 while the stored bit 16 is already 1 and the stored bit 24 is 0. A write that raises both bits from zero launches nothing.
- R4: A launched set issues the slots set in its command-enable bitmap (offset 0x1C) in ascending slot index, one per cycle in which req_valid and req_ready are both high. req_set, req_slot, req_addr, req_data and req_msgid carry the set, the slot and that slot's contents. When several sets are pending, the lowest set index is issued first.
- R5: While req_valid is high and req_ready is low, the request stays unchanged on the next cycle, even if a lower-numbered set is launched in the meantime.
- R6: The slot status word (slot offset 0x0C) has bit 8 for issued and bit 16 for completed. Issued is set by the handshake. Completed is set by a response (rsp_valid with rsp_set and rsp_slot) to an issued command whose message word has bit 8 set or whose wait bitmap bit (set offset 0x10) is set. A response to any other command is ignored. A launch clears both flags on every slot of the set.
- R7: A busy set reads status 0. It returns to idle one cycle after all of its enabled slots have been issued and all of its enabled, wait-marked slots have completed. Its interrupt status bit is set in that same cycle.
- R8: irq is high exactly when some bit is set in both the interrupt status and the interrupt enable (0x00, one bit per set). Writing 1 to a bit at 0x08 clears that status bit. A set that finishes in the same cycle as that clear leaves its bit set.
- R9: While a set is busy, writes to its wait bitmap, its command-enable bitmap and its slot words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address of the register access |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from reg_addr |
| req_valid | output | 1 | Downstream command present |
| req_ready | input | 1 | Downstream accepts the command |
| req_set | output | SW | Set index of the command |
| req_slot | output | CW | Slot index of the command |
| req_msgid | output | DW | Message word of the command |
| req_addr | output | DW | Target address of the command |
| req_data | output | DW | Payload of the command |
| rsp_valid | input | 1 | Response strobe |
| rsp_set | input | SW | Set index of the response |
| rsp_slot | input | CW | Slot index of the response |
| irq | output | 1 | Masked set-done interrupt |

## Verification
Two events can fall in the same cycle: a set finishing and software clearing that set's interrupt status bit. The bench provokes the collision with a set that has one wait-marked command. It presents that command's response in one cycle and the write-one-to-clear in the next cycle, which is the cycle in which the set finishes. It then reads the status register, and a surviving bit shows that the finish took priority. A second race is a higher-priority launch while a request is stalled. That case is judged by the order of the handshakes the bench logs.

// File: rtl/tcs_seq.sv
module tcs_seq #(
  parameter int NUM_SETS    = 2,
  parameter int NUM_CMDS    = 4,
  parameter int AW          = 12,
  parameter int DW          = 32,
  parameter int SET_BASE    = 16,
  parameter int SET_STRIDE  = 672,
  parameter int SLOT_BASE   = 48,
  parameter int SLOT_STRIDE = 20,
  localparam int SW = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int CW = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [SW-1:0] req_set,
  output logic [CW-1:0] req_slot,
  output logic [DW-1:0] req_msgid,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  input  logic          rsp_valid,
  input  logic [SW-1:0] rsp_set,
  input  logic [CW-1:0] rsp_slot,
  output logic          irq
);

  logic [NUM_SETS-1:0] busy, ie, ist, en_q, tr_q, fin;
  logic [NUM_SETS-1:0][NUM_CMDS-1:0] wt, cen, pend, iss, cpl;
  logic [DW-1:0] msgid [NUM_SETS][NUM_CMDS];
  logic [DW-1:0] caddr [NUM_SETS][NUM_CMDS];
  logic [DW-1:0] cdata [NUM_SETS][NUM_CMDS];
  logic          hold_q, found;
  logic [SW-1:0] hs, ss, ds;
  logic [CW-1:0] hc, sc, dc;
  logic          hit_set, hit_slot;
  logic [2:0]    fld;
  int            off, loc, so;

  always_comb begin
    off      = int'(reg_addr) - SET_BASE;
    hit_set  = (off >= 0) && (off < NUM_SETS * SET_STRIDE) && (reg_addr[1:0] == 2'b00);
    ds       = SW'(off / SET_STRIDE);
    loc      = off % SET_STRIDE;
    so       = loc - SLOT_BASE;
    hit_slot = hit_set && (so >= 0) && (so < NUM_CMDS * SLOT_STRIDE);
    dc       = CW'(so / SLOT_STRIDE);
    fld      = 3'((so % SLOT_STRIDE) / 4);
  end

  always_comb begin
    found = 1'b0;
    ss    = '0;
    sc    = '0;
    for (int s = 0; s < NUM_SETS; s++)
      for (int c = 0; c < NUM_CMDS; c++)
        if (!found && pend[s][c]) begin
          found = 1'b1;
          ss    = SW'(s);
          sc    = CW'(c);
        end
  end

  assign req_valid = found;
  assign req_set   = hold_q ? hs : ss;
  assign req_slot  = hold_q ? hc : sc;
  assign req_msgid = msgid[req_set][req_slot];
  assign req_addr  = caddr[req_set][req_slot];
  assign req_data  = cdata[req_set][req_slot];
  assign irq       = |(ist & ie);

  always_comb
    for (int s = 0; s < NUM_SETS; s++)
      fin[s] = busy[s] && (pend[s] == '0) && ((wt[s] & cen[s] & ~cpl[s]) == '0);

  always_comb begin
    reg_rdata = '0;
    if (!hit_set) begin
      case (int'(reg_addr))
        'h00: reg_rdata = DW'(ie);
        'h04: reg_rdata = DW'(ist);
        'h0C: reg_rdata = (DW'(NUM_CMDS) << 27) | DW'(NUM_SETS);
        default: ;
      endcase
    end else if (hit_slot) begin
      case (fld)
        3'd0: reg_rdata = msgid[ds][dc];
        3'd1: reg_rdata = caddr[ds][dc];
        3'd2: reg_rdata = cdata[ds][dc];
        3'd3: begin
          reg_rdata[8]  = iss[ds][dc];
          reg_rdata[16] = cpl[ds][dc];
        end
        default: ;
      endcase
    end else begin
      case (loc)
        'h10: reg_rdata = DW'(wt[ds]);
        'h14: begin
          reg_rdata[16] = en_q[ds];
          reg_rdata[24] = tr_q[ds];
        end
        'h18: reg_rdata = DW'(!busy[ds]);
        'h1C: reg_rdata = DW'(cen[ds]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0; ie <= '0; ist <= '0; en_q <= '0; tr_q <= '0;
      wt <= '0; cen <= '0; pend <= '0; iss <= '0; cpl <= '0;
      hold_q <= 1'b0; hs <= '0; hc <= '0;
      for (int s = 0; s < NUM_SETS; s++)
        for (int c = 0; c < NUM_CMDS; c++) begin
          msgid[s][c] <= '0;
          caddr[s][c] <= '0;
          cdata[s][c] <= '0;
        end
    end else begin
      hold_q <= req_valid && !req_ready;
      hs     <= req_set;
      hc     <= req_slot;
      if (req_valid && req_ready) begin
        pend[req_set][req_slot] <= 1'b0;
        iss[req_set][req_slot]  <= 1'b1;
      end
      if (rsp_valid && busy[rsp_set] && iss[rsp_set][rsp_slot] &&
          (msgid[rsp_set][rsp_slot][8] || wt[rsp_set][rsp_slot]))
        cpl[rsp_set][rsp_slot] <= 1'b1;
      for (int s = 0; s < NUM_SETS; s++) begin
        if (fin[s]) begin
          busy[s] <= 1'b0;
          ist[s]  <= 1'b1;
        end else if (reg_we && !hit_set && int'(reg_addr) == 'h08 && reg_wdata[s])
          ist[s] <= 1'b0;
      end
      if (reg_we) begin
        if (!hit_set) begin
          if (int'(reg_addr) == 'h00) ie <= reg_wdata[NUM_SETS-1:0];
        end else if (hit_slot) begin
          if (!busy[ds])
            case (fld)
              3'd0: msgid[ds][dc] <= reg_wdata;
              3'd1: caddr[ds][dc] <= reg_wdata;
              3'd2: cdata[ds][dc] <= reg_wdata;
              default: ;
            endcase
        end else begin
          case (loc)
            'h10: if (!busy[ds]) wt[ds] <= reg_wdata[NUM_CMDS-1:0];
            'h1C: if (!busy[ds]) cen[ds] <= reg_wdata[NUM_CMDS-1:0];
            'h14: begin
              en_q[ds] <= reg_wdata[16];
              tr_q[ds] <= reg_wdata[24];
              if (!busy[ds] && en_q[ds] && !tr_q[ds] && reg_wdata[24]) begin
                busy[ds] <= 1'b1;
                pend[ds] <= cen[ds];
                iss[ds]  <= '0;
                cpl[ds]  <= '0;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/tcs_seq_chk.sv
module tcs_seq_chk #(
  parameter int NUM_SETS = 2,
  parameter int NUM_CMDS = 4,
  parameter int DW       = 32,
  localparam int SW = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int CW = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              req_valid,
  input logic                              req_ready,
  input logic [SW-1:0]                     req_set,
  input logic [CW-1:0]                     req_slot,
  input logic [DW-1:0]                     req_addr,
  input logic [NUM_SETS-1:0]               busy,
  input logic [NUM_SETS-1:0]               ist,
  input logic [NUM_SETS-1:0][NUM_CMDS-1:0] pend,
  input logic [NUM_SETS-1:0][NUM_CMDS-1:0] iss,
  input logic [NUM_SETS-1:0][NUM_CMDS-1:0] cpl
);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_set) && $stable(req_slot) && $stable(req_addr));

  // R4
  issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy[req_set]);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    // R7
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[s]) |-> ist[s]);

    // R7
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[s] |-> pend[s] == '0);

    // R6
    cpl_after_iss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl[s] & ~iss[s]) == '0);
  end

endmodule

bind tcs_seq tcs_seq_chk #(.NUM_SETS(NUM_SETS), .NUM_CMDS(NUM_CMDS), .DW(DW)) u_chk (.*);

// File: tb/tcs_seq_tb.sv
module tcs_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic        req_set;
  logic [1:0]  req_slot;
  logic [31:0] req_msgid, req_addr, req_data;
  logic        rsp_valid = 1'b0;
  logic        rsp_set = 1'b0;
  logic [1:0]  rsp_slot = '0;
  logic        irq;

  int total = 0, bad = 0, nlog = 0;
  int log_s [32];
  int log_c [32];
  logic [31:0] log_a [32];

  always #10 clk = ~clk;

  tcs_seq u_dut (.*);

  always begin
    @(negedge clk); #5;
    if (req_valid && req_ready && nlog < 32) begin
      log_s[nlog] = int'(req_set);
      log_c[nlog] = int'(req_slot);
      log_a[nlog] = req_addr;
      nlog++;
    end
  end

  function automatic logic [11:0] sa(int s, int off);
    return 12'(16 + s * 672 + off);
  endfunction
  function automatic logic [11:0] ca(int s, int c, int off);
    return 12'(16 + s * 672 + 48 + c * 20 + off);
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fire(int s);
    wr(sa(s, 'h14), 32'h0001_0000);
    wr(sa(s, 'h14), 32'h0101_0000);
  endtask

  task automatic wait_idle(int s);
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      rd(sa(s, 'h18), v);
      if (v == 32'd1) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(sa(0, 'h18), v); check("R1 set0 idle", v, 1);
    rd(sa(1, 'h18), v); check("R1 set1 idle", v, 1);
    rd(12'h004, v);     check("R1 irq status", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 req_valid", {31'd0, req_valid}, 0);
    rd(12'h00C, v);     check("R2 config", v, 32'h2000_0002);
  endtask

  task automatic t_map;
    logic [31:0] v;
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 4; c++) begin
        wr(ca(s, c, 0), 32'h0001_0008);
        wr(ca(s, c, 4), 32'h100 + 32'(s * 16 + c));
        wr(ca(s, c, 8), 32'hD00 + 32'(s * 16 + c));
      end
    rd(ca(1, 3, 4), v); check("R2 addr s1c3", v, 32'h113);
    rd(ca(1, 3, 8), v); check("R2 data s1c3", v, 32'hD13);
    rd(ca(0, 2, 0), v); check("R2 msgid s0c2", v, 32'h0001_0008);
  endtask

  task automatic t_trigger;
    logic [31:0] v;
    wr(sa(0, 'h1C), 32'hB);
    wr(sa(0, 'h14), 32'h0101_0000);
    rd(sa(0, 'h18), v); check("R3 no launch on joint write", v, 1);
    check("R3 no request", {31'd0, req_valid}, 0);
    wr(sa(0, 'h14), 32'h0);
    req_ready = 1'b1;
    nlog = 0;
    fire(0);
    wait_idle(0);
    check("R4 count", 32'(nlog), 3);
    check("R4 first slot", 32'(log_c[0]), 0);
    check("R4 second slot", 32'(log_c[1]), 1);
    check("R4 third slot", 32'(log_c[2]), 3);
    check("R4 third addr", log_a[2], 32'h103);
    rd(ca(0, 0, 12), v); check("R6 slot0 issued only", v, 32'h100);
    rd(ca(0, 2, 12), v); check("R6 slot2 untouched", v, 0);
    rd(12'h004, v);      check("R7 status bit", v, 1);
    check("R8 masked irq", {31'd0, irq}, 0);
    wr(12'h000, 32'h1);
    check("R8 irq enabled", {31'd0, irq}, 1);
    wr(12'h008, 32'h1);
    rd(12'h004, v);      check("R8 cleared", v, 0);
    check("R8 irq low", {31'd0, irq}, 0);
  endtask

  task automatic t_stall;
    logic [31:0] v;
    req_ready = 1'b0;
    nlog = 0;
    wr(sa(1, 'h1C), 32'h3);
    fire(1);
    rd(sa(1, 'h18), v); check("R7 busy status", v, 0);
    wr(sa(1, 'h1C), 32'hF);
    wr(ca(1, 1, 4), 32'hBAD);
    rd(sa(1, 'h1C), v); check("R9 enable bitmap kept", v, 32'h3);
    rd(ca(1, 1, 4), v); check("R9 slot addr kept", v, 32'h111);
    fire(0);
    @(negedge clk);
    check("R5 held set", {31'd0, req_set}, 1);
    check("R5 held slot", {30'd0, req_slot}, 0);
    req_ready = 1'b1;
    wait_idle(1);
    wait_idle(0);
    check("R4 stall count", 32'(nlog), 5);
    check("R5 first is held", 32'(log_s[0] * 4 + log_c[0]), 4);
    check("R4 lower set next", 32'(log_s[1] * 4 + log_c[1]), 0);
    check("R4 order s0c3", 32'(log_s[3] * 4 + log_c[3]), 3);
    check("R4 last s1c1", 32'(log_s[4] * 4 + log_c[4]), 5);
    wr(12'h008, 32'h3);
    wr(12'h000, 32'h0);
  endtask

  task automatic t_wait;
    logic [31:0] v;
    wr(sa(0, 'h1C), 32'h3);
    wr(sa(0, 'h10), 32'h2);
    wr(ca(0, 1, 0), 32'h0001_0108);
    fire(0);
    repeat (6) @(negedge clk);
    rd(sa(0, 'h18), v); check("R7 waits for completion", v, 0);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_set = 1'b0; rsp_slot = 2'd0;
    @(negedge clk);
    rsp_valid = 1'b0;
    rd(ca(0, 0, 12), v); check("R6 unrequested response ignored", v, 32'h100);
    rd(12'h004, v);      check("R8 status clear before race", v, 0);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_slot = 2'd1;
    @(negedge clk);
    rsp_valid = 1'b0;
    reg_we = 1'b1; reg_addr = 12'h008; reg_wdata = 32'h1;
    @(negedge clk);
    reg_we = 1'b0;
    rd(12'h004, v);      check("R8 finish beats clear", v, 1);
    rd(ca(0, 1, 12), v); check("R6 completed", v, 32'h10100);
    rd(sa(0, 'h18), v);  check("R7 idle after completion", v, 1);
    wr(12'h008, 32'h1);
    rd(12'h004, v);      check("R8 plain clear", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_map;
    t_trigger;
    t_stall;
    t_wait;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule